// File: doc/BRIEF.md
# Two-Tone FSK Manchester Tag Waveform Generator

This block produces the one-bit load-modulation pattern that lets a reader-side board pose as a 44-bit frequency-shift-keyed proximity credential. A modulation output of 1 opens the coil and a 0 shorts it. Each sample is applied for one period of the reader's carrier clock. The carrier arrives as an asynchronous input. It is resynchronised, and each detected rising edge moves the pattern forward by one sample.

The waveform is made from two tones. The slow tone repeats every 8 samples and the fast tone every 10 samples. Each half of a Manchester bit holds a whole number of tone periods. A frame starts with a short spacer. A start marker follows, built from half-bit pairs that break the Manchester rules on purpose. Then come the 44 ID bits, most significant first, with a spacer in front of every group of four. The frame repeats without a gap for as long as the enable is held high. The ID is captured on the rising edge of the enable.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: After reset, `mod_o` is 0.
- R2: While `en_i` is low, `mod_o` is 0 and carrier edges have no effect. When `en_i` rises again, the frame restarts from its first sample, even if it was interrupted mid-frame.
- R3: Tone shapes and bit encoding:
  - An 8-tone period is the sample sequence 1,1,0,0,0,0,0,0.
  - A 10-tone period is 1,1,1,0,0,0,0,0,0,0.
  - A half-bit is either six 8-tone periods (48 samples) or five 10-tone periods (50 samples).
  - An ID bit of 1 is a 10-tone half-bit followed by an 8-tone half-bit. An ID bit of 0 is the reverse.
- R4: A frame opens with one single 8-tone period. It is followed by eight half-bits with tones 8,8,8,10,10,10,8,10 in that order.
- R5: ID bits are sent from bit 43 down to bit 0. One single 8-tone period is placed before every bit whose index modulo 4 equals 3.
- R6: A frame is 4800 samples long. After its last sample the next sample is the first sample of a new frame.
- R7: The output changes only in response to a detected carrier rising edge. Between carrier edges, `mod_o` holds its value.
- R8: `id_i` is sampled only in the cycle where `en_i` rises. Changes to `id_i` while enabled do not affect the waveform.
- R9: Each carrier rising edge produces exactly one one-cycle advance pulse after a two-flop synchroniser. `mod_o` shows the new sample within three `clk` cycles of the carrier rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the carrier |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; its rising edge captures the ID |
| id_i | input | 44 | ID to be emulated |
| carrier_i | input | 1 | Reader carrier clock, asynchronous |
| mod_o | output | 1 | Coil control: 1 opens the coil, 0 shorts it |

## Verification
The bench sweeps every one of the 4800 sample positions of a frame for two different IDs and compares each against an arithmetic model. One ID has set bits at both ends of the word, which exposes errors in group-spacer placement and bit order. A design with the Manchester halves swapped, a spacer misplaced, or an 8/10 tone mix-up would show a mismatch at a specific sample index. The bench runs two frames back to back, which catches an off-by-one in the frame wrap. It changes the ID mid-run, which catches a design that reads the live ID instead of the captured one. It drops the enable mid-frame and checks that the next frame starts from sample 0. Finally, it holds the carrier still and checks that no sample advances on its own.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;

  typedef enum logic [2:0] {
    ST_LEAD,
    ST_SOF,
    ST_SPC,
    ST_HALF1,
    ST_HALF2
  } seq_st_e;

  // A tone period is high for its first hi_len samples.
  function automatic logic tone_level(input int unsigned ph, input int unsigned hi_len);
    return ph < hi_len;
  endfunction

  // A spacer goes before the first bit of each group counted from the top.
  function automatic logic group_head(input int unsigned bit_idx, input int unsigned grp);
    return (bit_idx % grp) == (grp - 1);
  endfunction

  function automatic int unsigned frame_samples(input int unsigned id_w, input int unsigned grp,
                                                input int unsigned div_a, input int unsigned rep_a,
                                                input int unsigned div_b, input int unsigned rep_b,
                                                input int unsigned sof_halves);
    int unsigned half_a;
    int unsigned half_b;
    half_a = div_a * rep_a;
    half_b = div_b * rep_b;
    return div_a + (sof_halves / 2) * (half_a + half_b) + id_w * (half_a + half_b)
           + (id_w / grp) * div_a;
  endfunction

endpackage

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise_o = s2 & ~s3;
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned HI_A  = 2,
  parameter int unsigned REP_A = 6,
  parameter int unsigned DIV_B = 10,
  parameter int unsigned HI_B  = 3,
  parameter int unsigned REP_B = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic adv_i,
  input  logic is10_i,
  input  logic single_i,
  output logic level_o,
  output logic last_o
);
  import fsk_tag_pkg::*;

  localparam int unsigned MAXDIV = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int unsigned MAXREP = (REP_A > REP_B) ? REP_A : REP_B;
  localparam int unsigned PH_W   = $clog2(MAXDIV);
  localparam int unsigned RP_W   = (MAXREP > 1) ? $clog2(MAXREP) : 1;

  logic [PH_W-1:0] ph;
  logic [RP_W-1:0] rep;
  logic ph_end, rep_end;
  int unsigned div_cur, hi_cur, rep_cur;

  always_comb begin
    div_cur = is10_i ? DIV_B : DIV_A;
    hi_cur  = is10_i ? HI_B  : HI_A;
    rep_cur = is10_i ? REP_B : REP_A;
    ph_end  = (32'(ph) == div_cur - 1);
    rep_end = single_i || (32'(rep) == rep_cur - 1);
    level_o = tone_level(32'(ph), hi_cur);
    last_o  = ph_end && rep_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= '0;
      rep <= '0;
    end else if (clear_i) begin
      ph  <= '0;
      rep <= '0;
    end else if (adv_i) begin
      if (ph_end) begin
        ph  <= '0;
        rep <= rep_end ? '0 : rep + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq #(
  parameter int unsigned ID_W     = 44,
  parameter int unsigned GROUP    = 4,
  parameter int unsigned SOF_LEN  = 8,
  parameter logic [SOF_LEN-1:0] SOF_MASK = 8'b1011_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            step_i,
  input  logic [ID_W-1:0] id_i,
  output logic            is10_o,
  output logic            single_o,
  output logic            wrap_o
);
  import fsk_tag_pkg::*;

  localparam int unsigned BI_W = $clog2(ID_W);
  localparam int unsigned SI_W = $clog2(SOF_LEN);

  seq_st_e         st;
  logic [SI_W-1:0] sof_idx;
  logic [BI_W-1:0] bit_idx;
  logic [BI_W-1:0] nb;

  assign nb = bit_idx - 1'b1;

  always_comb begin
    is10_o   = 1'b0;
    single_o = 1'b0;
    case (st)
      ST_LEAD, ST_SPC: single_o = 1'b1;
      ST_SOF:          is10_o   = SOF_MASK[sof_idx];
      ST_HALF1:        is10_o   = id_i[bit_idx];
      ST_HALF2:        is10_o   = ~id_i[bit_idx];
      default:         single_o = 1'b1;
    endcase
  end

  assign wrap_o = step_i && (st == ST_HALF2) && (bit_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_LEAD;
      sof_idx <= '0;
      bit_idx <= '0;
    end else if (clear_i) begin
      st      <= ST_LEAD;
      sof_idx <= '0;
      bit_idx <= '0;
    end else if (step_i) begin
      case (st)
        ST_LEAD: begin
          st      <= ST_SOF;
          sof_idx <= '0;
        end
        ST_SOF: begin
          if (32'(sof_idx) == SOF_LEN - 1) begin
            bit_idx <= BI_W'(ID_W - 1);
            st      <= group_head(ID_W - 1, GROUP) ? ST_SPC : ST_HALF1;
          end else begin
            sof_idx <= sof_idx + 1'b1;
          end
        end
        ST_SPC:   st <= ST_HALF1;
        ST_HALF1: st <= ST_HALF2;
        ST_HALF2: begin
          if (bit_idx == '0) begin
            st <= ST_LEAD;
          end else begin
            bit_idx <= nb;
            st      <= group_head(32'(nb), GROUP) ? ST_SPC : ST_HALF1;
          end
        end
        default: st <= ST_LEAD;
      endcase
    end
  end
endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen #(
  parameter int unsigned ID_W  = 44,
  parameter int unsigned GROUP = 4,
  parameter int unsigned DIV_A = 8,
  parameter int unsigned HI_A  = 2,
  parameter int unsigned REP_A = 6,
  parameter int unsigned DIV_B = 10,
  parameter int unsigned HI_B  = 3,
  parameter int unsigned REP_B = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            carrier_i,
  output logic            mod_o
);
  logic            en_q;
  logic [ID_W-1:0] id_q;
  logic            edge_w, adv_w, clear_w, step_w, wrap_w;
  logic            is10_w, single_w, level_w, last_w;

  fsk_edge_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (carrier_i),
    .rise_o  (edge_w)
  );

  assign adv_w   = edge_w & en_i;
  assign clear_w = ~en_i;
  assign step_w  = adv_w & last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      id_q <= '0;
    end else begin
      en_q <= en_i;
      if (en_i && !en_q) id_q <= id_i;
    end
  end

  fsk_tone_gen #(
    .DIV_A(DIV_A), .HI_A(HI_A), .REP_A(REP_A),
    .DIV_B(DIV_B), .HI_B(HI_B), .REP_B(REP_B)
  ) u_tone (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear_w),
    .adv_i    (adv_w),
    .is10_i   (is10_w),
    .single_i (single_w),
    .level_o  (level_w),
    .last_o   (last_w)
  );

  fsk_frame_seq #(
    .ID_W(ID_W), .GROUP(GROUP)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear_w),
    .step_i   (step_w),
    .id_i     (id_q),
    .is10_o   (is10_w),
    .single_o (single_w),
    .wrap_o   (wrap_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mod_o <= 1'b0;
    else if (!en_i) mod_o <= 1'b0;
    else if (adv_w) mod_o <= level_w;
  end
endmodule

// File: rtl/fsk_tag_wavegen_chk.sv
module fsk_tag_wavegen_chk #(
  parameter int unsigned ID_W  = 44,
  parameter int unsigned GROUP = 4,
  parameter int unsigned DIV_A = 8,
  parameter int unsigned REP_A = 6,
  parameter int unsigned DIV_B = 10,
  parameter int unsigned REP_B = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_i,
  input logic            en_q,
  input logic [ID_W-1:0] id_q,
  input logic            edge_w,
  input logic            adv_w,
  input logic            wrap_w,
  input logic            mod_o
);
  import fsk_tag_pkg::*;

  localparam int unsigned FRAME_LEN = frame_samples(ID_W, GROUP, DIV_A, REP_A, DIV_B, REP_B, 8);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en_i)  cnt <= '0;
    else if (adv_w)  cnt <= wrap_w ? '0 : cnt + 1'b1;
  end

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !mod_o);

  assert_hold_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !edge_w) |=> $stable(mod_o));

  assert_frame_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |-> (32'(cnt) == FRAME_LEN - 1));

  assert_id_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && en_q) |=> $stable(id_q));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> !edge_w);
endmodule

bind fsk_tag_wavegen fsk_tag_wavegen_chk #(
  .ID_W(ID_W), .GROUP(GROUP), .DIV_A(DIV_A), .REP_A(REP_A), .DIV_B(DIV_B), .REP_B(REP_B)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en_i   (en_i),
  .en_q   (en_q),
  .id_q   (id_q),
  .edge_w (edge_w),
  .adv_w  (adv_w),
  .wrap_w (wrap_w),
  .mod_o  (mod_o)
);

// File: tb/fsk_tag_wavegen_bench.sv
module fsk_tag_wavegen_bench;
  localparam int FRAME = 4800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [43:0] id_i = '0;
  logic        carrier_i = 1'b0;
  logic        mod_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n;

  bit  exp_bit [0:FRAME-1];
  byte exp_tag [0:FRAME-1];

  always #10 clk = ~clk;

  fsk_tag_wavegen u_fsk_tag_wavegen (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .id_i(id_i),
    .carrier_i(carrier_i), .mod_o(mod_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One tone period: period 8 high for 2, period 10 high for 3 (R3).
  task automatic put_period(input int period, input byte tag);
    for (int k = 0; k < period; k++) begin
      exp_bit[n] = (k < ((period == 8) ? 2 : 3));
      exp_tag[n] = tag;
      n++;
    end
  endtask

  task automatic put_half(input int period, input byte tag);
    for (int r = 0; r < ((period == 8) ? 6 : 5); r++) put_period(period, tag);
  endtask

  task automatic build(input logic [43:0] id);
    int sof [8] = '{8, 8, 8, 10, 10, 10, 8, 10};
    n = 0;
    put_period(8, 4);
    foreach (sof[i]) put_half(sof[i], 4);
    for (int b = 43; b >= 0; b--) begin
      if (b % 4 == 3) put_period(8, 5);
      if (id[b]) begin put_half(10, 3); put_half(8, 3); end
      else       begin put_half(8, 3);  put_half(10, 3); end
    end
  endtask

  // Entered at a negedge; one carrier period of 6 clk cycles.
  task automatic pulse(output logic got);
    carrier_i = 1'b1;
    repeat (3) @(negedge clk);
    carrier_i = 1'b0;
    repeat (2) @(negedge clk);
    got = mod_o;
    @(negedge clk);
  endtask

  function automatic string tag_name(input byte t);
    if (t == 4) return "R4";
    if (t == 5) return "R5";
    return "R3";
  endfunction

  task automatic run(input int first, input int last, input string extra, input int hold_at);
    logic got;
    for (int i = first; i <= last; i++) begin
      pulse(got);
      check({tag_name(exp_tag[i]), extra, $sformatf(" sample %0d", i)}, 64'(got), 64'(exp_bit[i]));
      if (i == hold_at) begin
        repeat (40) @(negedge clk);
        check("R7 output held without carrier edge", 64'(mod_o), 64'(got));
      end
    end
  endtask

  initial begin
    logic got;
    logic [43:0] id_a = 44'h5A3C96E1F0B;
    logic [43:0] id_b = 44'h80000000001;

    repeat (4) @(negedge clk);
    check("R1 mod low in reset", 64'(mod_o), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 mod low after reset", 64'(mod_o), 64'd0);

    for (int i = 0; i < 5; i++) begin
      pulse(got);
      check("R2 disabled ignores carrier", 64'(got), 64'd0);
    end

    // Two back-to-back frames with ID A; the input ID changes midway (R8).
    build(id_a);
    id_i = id_a;
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 2399, "", -1);
    id_i = id_b;
    run(2400, FRAME - 1, " R8", -1);
    run(0, FRAME - 1, " R6 R8", -1);

    en_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 mod low after disable", 64'(mod_o), 64'd0);
    for (int i = 0; i < 10; i++) begin
      pulse(got);
      check("R2 disabled ignores carrier", 64'(got), 64'd0);
    end

    // ID B: interrupt mid-frame, then a full frame from restart.
    build(id_b);
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 999, "", -1);
    en_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 mod low on mid-frame disable", 64'(mod_o), 64'd0);
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 449, " R2 restart", -1);
    run(450, FRAME - 1, "", 600);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule